// File: doc/BRIEF.md
# Hot-Swap Fault Latch and Alert Controller

This block holds the fault-tracking state of a power-switch supervisor. Live condition flags come in from analog comparators: overvoltage, undervoltage, overcurrent, a low-feedback (power-bad) flag and a switch-short flag. Alongside them arrive a card-present level, a gate-on level, a switch-enable pin, an undervoltage-reset input and a supply-lockout input. Each of these inputs passes through a synchronizer. The block then latches the conditions into a fault register, drives an active-low alert through a per-bit enable mask, and decides whether the power switch may be on.

A small synchronous register port writes and reads four registers. Address 0 is control, address 1 is the alert mask, address 2 is the read-only live status and address 3 is the fault register. An alert-response acknowledge input and a "device addressed" input release the alert. The alert is re-armed only by a fault bit that is newly set.

Top module: `hsw_fault_ctrl`

## Requirements
- R1: After reset the fault register (address 3) and the alert mask (address 1) read 0, control (address 0) reads 0x01, `alert_oe` is 0, and `switch_on` is 0 while the enable pin is low.
- R2: Status (address 2) has these bits: bit0 overvoltage, bit1 undervoltage, bit2 overcurrent, bit3 power-bad, bit4 card present, bit5 switch short, bit6 gate on. The status bits follow the synchronized inputs with no latching. `pgood_low` is 1 exactly while status bit3 is 1.
- R3: The fault register has these bits: bit0 overvoltage, bit1 undervoltage, bit2 overcurrent, bit3 power-bad, bit4 card-removed, bit5 switch short. Fault bit3 is set only while power-bad and gate-on are both high.
- R4: `alert_oe` asserts only for a set fault bit whose alert-mask bit (same position) is 1. With the mask all zero, no alert occurs.
- R5: A pulse on `ara_ack` or on `bus_addressed` releases `alert_oe`.
- R6: After release, `alert_oe` stays low until a different fault bit sets, or until a reported bit is cleared and then set again. A fault that repeats while its bit is still set raises no alert.
- R7: Writing address 3 clears each fault bit written as 0. A bit whose live condition is still present stays set.
- R8: The whole fault register clears on a falling edge of the effective enable, which is the enable pin AND control bit0. It also clears while the undervoltage-reset input or the lockout input is high.
- R9: On a falling edge of card-present, fault bits 0–3 and bit5 clear and bit4 is set.
- R10: When control bit1 is 0 (latched mode), `switch_on` is 1 only when the effective enable is 1 and fault bits 0–2 are all zero.
- R11: When control bit1 is 1 (auto-retry), `switch_on` is gated by status bits 0–2 instead of fault bits 0–2. The fault register keeps its contents.
- R12: Within a cycle, live set conditions override a write-clear, and the clear events of R8 and R9 override both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ov_in | input | 1 | Overvoltage comparator flag (async) |
| uv_in | input | 1 | Undervoltage comparator flag (async) |
| oc_in | input | 1 | Overcurrent flag (async) |
| fb_low_in | input | 1 | Feedback below power-good threshold (async) |
| short_in | input | 1 | Switch short flag (async) |
| card_in | input | 1 | Card present level (async) |
| gate_on_in | input | 1 | Gate drive is on (async) |
| en_pin_in | input | 1 | Switch enable pin (async) |
| uv_reset_in | input | 1 | Undervoltage reset (async) |
| lockout_in | input | 1 | Supply lockout (async) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| ara_ack | input | 1 | Alert-response acknowledge pulse |
| bus_addressed | input | 1 | Device addressed by the bus master |
| alert_oe | output | 1 | Pull alert line low when 1 |
| pgood_low | output | 1 | Pull power-good low when 1 |
| switch_on | output | 1 | Power switch allowed on |

## Verification
The hardest behaviour to reach is the re-arm rule. It needs a fault bit that has already been reported, stays set, and sees its live cause toggle, and then separately needs that same bit cleared and set again. The stimulus reaches this by enabling the mask after a power-bad fault and acknowledging the alert. It then pulses the feedback flag while the bit stays latched, and afterwards clears and re-raises overvoltage. Priority between set, write-clear and forced clear is shown by holding a live flag while a write-clear or an undervoltage reset is applied.

// File: rtl/hsw_fault_pkg.sv
package hsw_fault_pkg;
   localparam int FAULT_W = 6;
   localparam int STAT_W  = 7;
   localparam int FB_OV    = 0;
   localparam int FB_UV    = 1;
   localparam int FB_OC    = 2;
   localparam int FB_PBAD  = 3;
   localparam int FB_CARD  = 4;
   localparam int FB_SHORT = 5;
   localparam int SB_GATE  = 6;
   localparam int CB_EN    = 0;
   localparam int CB_RETRY = 1;
   typedef enum logic [1:0] {
      RA_CTRL  = 2'd0,
      RA_MASK  = 2'd1,
      RA_STAT  = 2'd2,
      RA_FAULT = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/hsw_fault_reg.sv
module hsw_fault_reg
   import hsw_fault_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FAULT_W-1:0] live_set,
   input  logic               wr_clr,
   input  logic [FAULT_W-1:0] wr_keep,
   input  logic               card_fall,
   input  logic               clr_all,
   output logic [FAULT_W-1:0] fault_q,
   output logic [FAULT_W-1:0] fault_nx
);
   always_comb begin
      fault_nx = fault_q;
      if (wr_clr) fault_nx = fault_nx & wr_keep;
      fault_nx = fault_nx | live_set;
      if (card_fall) begin
         fault_nx[FB_OV]    = 1'b0;
         fault_nx[FB_UV]    = 1'b0;
         fault_nx[FB_OC]    = 1'b0;
         fault_nx[FB_PBAD]  = 1'b0;
         fault_nx[FB_SHORT] = 1'b0;
         fault_nx[FB_CARD]  = 1'b1;
      end
      if (clr_all) fault_nx = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fault_q <= '0;
      else        fault_q <= fault_nx;
   end
endmodule

// File: rtl/hsw_alert_arm.sv
module hsw_alert_arm
   import hsw_fault_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FAULT_W-1:0] fault_q,
   input  logic [FAULT_W-1:0] fault_nx,
   input  logic [FAULT_W-1:0] mask_q,
   input  logic               ack,
   output logic               alert_oe
);
   logic [FAULT_W-1:0] told_q;
   logic [FAULT_W-1:0] told_nx;

   always_comb begin
      told_nx = ack ? (fault_q & mask_q) : told_q;
      told_nx = told_nx & fault_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) told_q <= '0;
      else        told_q <= told_nx;
   end

   assign alert_oe = |(fault_q & mask_q & ~told_q);
endmodule

// File: rtl/hsw_fault_ctrl.sv
module hsw_fault_ctrl
   import hsw_fault_pkg::*;
#(
   parameter int          DW          = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  CTRL_RESET  = 8'h01
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ov_in,
   input  logic          uv_in,
   input  logic          oc_in,
   input  logic          fb_low_in,
   input  logic          short_in,
   input  logic          card_in,
   input  logic          gate_on_in,
   input  logic          en_pin_in,
   input  logic          uv_reset_in,
   input  logic          lockout_in,
   input  logic          reg_wr,
   input  logic [1:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          ara_ack,
   input  logic          bus_addressed,
   output logic          alert_oe,
   output logic          pgood_low,
   output logic          switch_on
);
   localparam int NSYNC = 10;

   if (DW < 8) begin : g_bad_dw
      $error("hsw_fault_ctrl: DW must be at least 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hsw_fault_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [NSYNC-1:0] raw_vec, syn_vec;
   assign raw_vec = {lockout_in, uv_reset_in, en_pin_in, gate_on_in, card_in,
                     short_in, fb_low_in, oc_in, uv_in, ov_in};

   hsw_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_vec), .q(syn_vec)
   );

   logic ov_s, uv_s, oc_s, pbad_s, short_s, card_s, gate_s, en_s, uvr_s, lock_s;
   assign {lock_s, uvr_s, en_s, gate_s, card_s, short_s, pbad_s, oc_s, uv_s, ov_s} = syn_vec;

   logic [STAT_W-1:0] st_vec;
   always_comb begin
      st_vec           = '0;
      st_vec[FB_OV]    = ov_s;
      st_vec[FB_UV]    = uv_s;
      st_vec[FB_OC]    = oc_s;
      st_vec[FB_PBAD]  = pbad_s;
      st_vec[FB_CARD]  = card_s;
      st_vec[FB_SHORT] = short_s;
      st_vec[SB_GATE]  = gate_s;
   end

   logic [DW-1:0]      ctrl_q;
   logic [FAULT_W-1:0] mask_q;
   logic               wr_ctrl, wr_mask, wr_fault;
   assign wr_ctrl  = reg_wr && (reg_addr_e'(reg_addr) == RA_CTRL);
   assign wr_mask  = reg_wr && (reg_addr_e'(reg_addr) == RA_MASK);
   assign wr_fault = reg_wr && (reg_addr_e'(reg_addr) == RA_FAULT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= DW'(CTRL_RESET);
         mask_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= reg_wdata;
         if (wr_mask) mask_q <= reg_wdata[FAULT_W-1:0];
      end
   end

   logic en_eff, en_prev, card_prev, en_fall, card_fall, clr_all;
   assign en_eff = en_s & ctrl_q[CB_EN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_prev   <= 1'b0;
         card_prev <= 1'b0;
      end else begin
         en_prev   <= en_eff;
         card_prev <= card_s;
      end
   end

   assign en_fall   = en_prev & ~en_eff;
   assign card_fall = card_prev & ~card_s;
   assign clr_all   = en_fall | uvr_s | lock_s;

   logic [FAULT_W-1:0] live_set;
   always_comb begin
      live_set           = '0;
      live_set[FB_OV]    = ov_s;
      live_set[FB_UV]    = uv_s;
      live_set[FB_OC]    = oc_s;
      live_set[FB_PBAD]  = pbad_s & gate_s;
      live_set[FB_SHORT] = short_s;
   end

   logic [FAULT_W-1:0] fault_q, fault_nx;
   hsw_fault_reg u_freg (
      .clk(clk), .rst_n(rst_n), .live_set(live_set), .wr_clr(wr_fault),
      .wr_keep(reg_wdata[FAULT_W-1:0]), .card_fall(card_fall), .clr_all(clr_all),
      .fault_q(fault_q), .fault_nx(fault_nx)
   );

   logic ack_any;
   assign ack_any = ara_ack | bus_addressed;

   hsw_alert_arm u_alert (
      .clk(clk), .rst_n(rst_n), .fault_q(fault_q), .fault_nx(fault_nx),
      .mask_q(mask_q), .ack(ack_any), .alert_oe(alert_oe)
   );

   logic hold_off;
   always_comb begin
      if (ctrl_q[CB_RETRY]) hold_off = |st_vec[FB_OC:FB_OV];
      else                  hold_off = |fault_q[FB_OC:FB_OV];
   end
   assign switch_on = en_eff & ~hold_off;
   assign pgood_low = pbad_s;

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr_e'(reg_addr))
         RA_CTRL:  reg_rdata = ctrl_q;
         RA_MASK:  reg_rdata[FAULT_W-1:0] = mask_q;
         RA_STAT:  reg_rdata[STAT_W-1:0]  = st_vec;
         RA_FAULT: reg_rdata[FAULT_W-1:0] = fault_q;
      endcase
   end
endmodule

// File: rtl/hsw_fault_chk.sv
module hsw_fault_chk
   import hsw_fault_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic [FAULT_W-1:0] fault_q,
   input logic [FAULT_W-1:0] fault_nx,
   input logic [FAULT_W-1:0] mask_q,
   input logic [2:0]         st_low,
   input logic               retry,
   input logic               clr_all,
   input logic               card_fall,
   input logic               ack_any,
   input logic               reg_wr,
   input logic               alert_oe,
   input logic               switch_on,
   input logic               pbad_s,
   input logic               gate_s,
   input logic               ov_s
);
   // R4
   mask_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !alert_oe);
   // R3
   pbad_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_q[FB_PBAD]) |-> $past(pbad_s && gate_s));
   // R7
   live_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_s && !clr_all && !card_fall) |=> fault_q[FB_OV]);
   // R8
   clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (fault_q == '0));
   // R9
   card_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (card_fall && !clr_all) |=> (fault_q == (FAULT_W'(1) << FB_CARD)));
   // R10
   latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!retry && |fault_q[2:0]) |-> !switch_on);
   // R11
   retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retry && |st_low) |-> !switch_on);
   // R5
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_any && fault_nx == fault_q && !reg_wr) |=> !alert_oe);
endmodule

bind hsw_fault_ctrl hsw_fault_chk u_chk (
   .clk(clk), .rst_n(rst_n), .fault_q(fault_q), .fault_nx(fault_nx),
   .mask_q(mask_q), .st_low(st_vec[2:0]), .retry(ctrl_q[1]),
   .clr_all(clr_all), .card_fall(card_fall), .ack_any(ack_any),
   .reg_wr(reg_wr), .alert_oe(alert_oe), .switch_on(switch_on),
   .pbad_s(pbad_s), .gate_s(gate_s), .ov_s(ov_s)
);

// File: tb/hsw_fault_ctrl_tb.sv
`timescale 1ns/1ps
module hsw_fault_ctrl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ov_in = 0, uv_in = 0, oc_in = 0, fb_low_in = 0, short_in = 0;
   logic card_in = 0, gate_on_in = 0, en_pin_in = 0, uv_reset_in = 0, lockout_in = 0;
   logic reg_wr = 0;
   logic [1:0] reg_addr = 0;
   logic [7:0] reg_wdata = 0;
   logic [7:0] reg_rdata;
   logic ara_ack = 0, bus_addressed = 0;
   logic alert_oe, pgood_low, switch_on;

   always #2.5 clk = ~clk;

   hsw_fault_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ov_in(ov_in), .uv_in(uv_in), .oc_in(oc_in),
      .fb_low_in(fb_low_in), .short_in(short_in), .card_in(card_in),
      .gate_on_in(gate_on_in), .en_pin_in(en_pin_in), .uv_reset_in(uv_reset_in),
      .lockout_in(lockout_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ara_ack(ara_ack),
      .bus_addressed(bus_addressed), .alert_oe(alert_oe), .pgood_low(pgood_low),
      .switch_on(switch_on)
   );

   typedef struct {
      int         kind;   // 0 register, 1 alert, 2 pgood, 3 switch
      logic [1:0] addr;
      logic [7:0] exp;
      string      req;
   } item_t;

   item_t q[$];
   int checks = 0;
   int fails = 0;
   bit done = 0;

   // monitor: compares the oldest expected item against the design
   initial begin
      forever begin
         item_t it;
         logic [7:0] act;
         @(negedge clk);
         if (q.size() > 0) begin
            it = q[0];
            act = '0;
            case (it.kind)
               0: begin reg_addr = it.addr; #1; act = reg_rdata; end
               1: act = {7'b0, alert_oe};
               2: act = {7'b0, pgood_low};
               default: act = {7'b0, switch_on};
            endcase
            checks++;
            if (act !== it.exp) begin
               fails++;
               $display("FAIL %s kind=%0d addr=%0d actual=0x%02h expected=0x%02h",
                        it.req, it.kind, it.addr, act, it.exp);
            end
            void'(q.pop_front());
         end
      end
   end

   task automatic expect_item(input int kind, input logic [1:0] a,
                              input logic [7:0] e, input string req);
      item_t it;
      it.kind = kind; it.addr = a; it.exp = e; it.req = req;
      q.push_back(it);
      wait (q.size() == 0);
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
      settle();
   endtask

   task automatic pulse_ack(input bit addressed);
      @(negedge clk);
      if (addressed) bus_addressed = 1; else ara_ack = 1;
      @(negedge clk);
      bus_addressed = 0; ara_ack = 0;
      settle();
   endtask

   initial begin
      #1000000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;
      settle();
      // R1 reset state
      expect_item(0, 3, 8'h00, "R1");
      expect_item(0, 1, 8'h00, "R1");
      expect_item(0, 0, 8'h01, "R1");
      expect_item(1, 0, 8'h00, "R1");
      expect_item(3, 0, 8'h00, "R1");
      // R10 enable with no faults
      en_pin_in = 1; card_in = 1; settle();
      expect_item(3, 0, 8'h01, "R10");
      expect_item(0, 2, 8'h10, "R2");
      // R2 R3 power bad while gate off: no fault
      fb_low_in = 1; settle();
      expect_item(0, 2, 8'h18, "R2");
      expect_item(2, 0, 8'h01, "R2");
      expect_item(0, 3, 8'h00, "R3");
      gate_on_in = 1; settle();
      expect_item(0, 3, 8'h08, "R3");
      expect_item(1, 0, 8'h00, "R4");
      fb_low_in = 0; settle();
      expect_item(2, 0, 8'h00, "R2");
      expect_item(0, 2, 8'h50, "R2");
      expect_item(0, 3, 8'h08, "R3");
      // R4 mask opens alert
      wr(1, 8'h3F);
      expect_item(1, 0, 8'h01, "R4");
      pulse_ack(0);
      expect_item(1, 0, 8'h00, "R5");
      // R6 repeat of a set fault: no alert
      fb_low_in = 1; settle(); fb_low_in = 0; settle();
      expect_item(0, 3, 8'h08, "R6");
      expect_item(1, 0, 8'h00, "R6");
      // R6 new bit re-alerts; R10 latched hold
      ov_in = 1; settle();
      expect_item(0, 3, 8'h09, "R6");
      expect_item(1, 0, 8'h01, "R6");
      expect_item(3, 0, 8'h00, "R10");
      pulse_ack(1);
      expect_item(1, 0, 8'h00, "R5");
      // R7 R12 write-clear with live flag held
      wr(3, 8'h00);
      expect_item(0, 3, 8'h01, "R7");
      expect_item(0, 3, 8'h01, "R12");
      ov_in = 0; settle();
      expect_item(3, 0, 8'h00, "R10");
      wr(3, 8'h00);
      expect_item(0, 3, 8'h00, "R7");
      expect_item(3, 0, 8'h01, "R10");
      // R6 clear then set again re-alerts
      ov_in = 1; settle();
      expect_item(1, 0, 8'h01, "R6");
      pulse_ack(0);
      // R8 R12 uv reset overrides live set
      uv_reset_in = 1; settle();
      expect_item(0, 3, 8'h00, "R8");
      expect_item(0, 3, 8'h00, "R12");
      uv_reset_in = 0; settle();
      expect_item(0, 3, 8'h01, "R12");
      ov_in = 0; settle();
      wr(3, 8'h00);
      // R4 masked-out bit raises no alert
      wr(1, 8'h01);
      oc_in = 1; settle(); oc_in = 0; settle();
      expect_item(0, 3, 8'h04, "R4");
      expect_item(1, 0, 8'h00, "R4");
      // R8 control enable bit falling
      wr(0, 8'h00);
      expect_item(0, 3, 8'h00, "R8");
      expect_item(3, 0, 8'h00, "R8");
      wr(0, 8'h01);
      expect_item(3, 0, 8'h01, "R8");
      // R8 lockout
      uv_in = 1; settle(); uv_in = 0; settle();
      expect_item(0, 3, 8'h02, "R8");
      lockout_in = 1; settle(); lockout_in = 0; settle();
      expect_item(0, 3, 8'h00, "R8");
      // R8 enable pin falling
      uv_in = 1; settle(); uv_in = 0; settle();
      en_pin_in = 0; settle();
      expect_item(0, 3, 8'h00, "R8");
      en_pin_in = 1; settle();
      // R9 card removal
      wr(1, 8'h3F);
      short_in = 1; settle(); short_in = 0; settle();
      expect_item(1, 0, 8'h01, "R4");
      pulse_ack(0);
      oc_in = 1; settle(); oc_in = 0; settle();
      expect_item(0, 3, 8'h24, "R9");
      pulse_ack(0);
      card_in = 0; settle();
      expect_item(0, 3, 8'h10, "R9");
      expect_item(1, 0, 8'h01, "R9");
      pulse_ack(0);
      card_in = 1; settle();
      // R11 auto-retry gates on live status
      wr(0, 8'h03);
      wr(3, 8'h00);
      oc_in = 1; settle();
      expect_item(3, 0, 8'h00, "R11");
      oc_in = 0; settle();
      expect_item(3, 0, 8'h01, "R11");
      expect_item(0, 3, 8'h04, "R11");
      wr(0, 8'h01);
      expect_item(3, 0, 8'h00, "R10");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule